// File: doc/BRIEF.md
# BF16 to FP32 Widening Converter

This block widens one brain-float (16-bit: sign, 8-bit exponent, 7-bit fraction) operand to single precision. The operand comes in as a floating-point register value of width FLEN (32 or 64), in its low 16 bits. It is accepted only if every bit above bit 15 is 1, which is the NaN-boxing rule. The result is a register-width value: the FP32 encoding in bits 31:0 and, when FLEN is 64, all ones above.

The widening is exact because brain-float is the top half of an FP32 encoding. For every non-NaN operand, including zeros, subnormals and infinities, the 16 bits move to the top of the FP32 word and zeros fill the low half. Every NaN result is the canonical quiet NaN. A signalling NaN operand raises the invalid flag, which is the only exception this conversion can raise. An operand that is not properly boxed counts as a canonical quiet NaN and raises nothing.

Results are registered and appear one clock after the input strobe. Between strobes, the result and the flag hold their last values.

Top module: `bf16_widen`

## Requirements
- R1: For a boxed operand whose exponent field (bits 14:7) is not all ones, or whose fraction (bits 6:0) is zero, result bits 31:0 equal the 16-bit operand followed by sixteen zero bits.
- R2: When FLEN is 64, result bits 63:32 are all ones for every conversion.
- R3: If any input bit from bit 16 upward is 0, result bits 31:0 are 0x7FC00000 and the invalid flag is 0.
- R4: A boxed signalling NaN operand gives result bits 31:0 = 0x7FC00000 and invalid = 1. A signalling NaN has exponent all ones, a nonzero fraction and fraction bit 6 equal to 0.
- R5: A boxed quiet NaN operand (exponent all ones, fraction bit 6 = 1) gives 0x7FC00000 and invalid = 0, whatever its sign and payload.
- R6: The invalid flag is 0 for every conversion other than that of a boxed signalling NaN.
- R7: out_vld is 1 exactly in the cycle after a cycle with in_vld = 1. While in_vld is 0, out_res and out_invalid keep their values.
- R8: After reset, out_vld, out_res and out_invalid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand strobe |
| in_reg | input | FLEN | Register value with the operand in bits 15:0 |
| out_vld | output | 1 | Result strobe, one cycle after in_vld |
| out_res | output | FLEN | Widened, boxed result |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
Directed operands cover both zeros, the smallest subnormal, the largest finite value, both infinities, signalling and quiet NaNs of either sign, and registers whose box is broken in only one upper bit. These separate the pass-through path from the NaN path, and the signalling check from the quiet check. Random operands are drawn with the exponent biased toward 0x00 and 0xFF, so subnormals and NaNs come up often. A share of them have random upper bits, which exercises the box check on top of every class. Idle cycles between strobes show whether the result and the flag hold their values.

// File: rtl/bf16w_pkg.sv
package bf16w_pkg;
  localparam int BF_W      = 16;
  localparam int SP_W      = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 7;
  localparam int PAD_W     = SP_W - BF_W;
  localparam logic [SP_W-1:0] SP_CANON_QNAN = 32'h7FC0_0000;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } bf16_t;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } bf_class_t;
endpackage

// File: rtl/bf16w_unbox.sv
module bf16w_unbox
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] reg_val,
  output bf16_t           operand,
  output logic            boxed_ok
);
  localparam int UPPER_W = FLEN - BF_W;

  logic [UPPER_W-1:0] upper;

  always_comb begin
    upper    = reg_val[FLEN-1:BF_W];
    boxed_ok = &upper;
    operand  = bf16_t'(reg_val[BF_W-1:0]);
  end
endmodule

// File: rtl/bf16w_classify.sv
module bf16w_classify
  import bf16w_pkg::*;
(
  input  logic [EXP_W-1:0]  expo,
  input  logic [FRAC_W-1:0] frac,
  output bf_class_t         cls
);
  logic exp_max;
  logic frac_nz;

  always_comb begin
    exp_max     = &expo;
    frac_nz     = |frac;
    cls.is_nan  = exp_max && frac_nz;
    cls.is_snan = exp_max && frac_nz && !frac[FRAC_W-1];
  end
endmodule

// File: rtl/bf16w_expand.sv
module bf16w_expand
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  bf16_t           operand,
  input  bf_class_t       cls,
  input  logic            boxed_ok,
  output logic [FLEN-1:0] result,
  output logic            invalid
);
  logic [SP_W-1:0] sp_word;
  logic            force_nan;

  always_comb begin
    force_nan = !boxed_ok || cls.is_nan;
    sp_word   = force_nan ? SP_CANON_QNAN : {operand, {PAD_W{1'b0}}};
    invalid   = boxed_ok && cls.is_snan;
  end

  generate
    if (FLEN > SP_W) begin : g_box
      always_comb result = {{(FLEN-SP_W){1'b1}}, sp_word};
    end else begin : g_nobox
      always_comb result = sp_word;
    end
  endgenerate
endmodule

// File: rtl/bf16_widen.sv
module bf16_widen
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [FLEN-1:0] in_reg,
  output logic            out_vld,
  output logic [FLEN-1:0] out_res,
  output logic            out_invalid
);
  bf16_t           op;
  logic            boxed_ok;
  bf_class_t       cls;
  logic [FLEN-1:0] conv_res;
  logic            conv_inv;

  logic            vld_d, vld_q;
  logic [FLEN-1:0] res_d, res_q;
  logic            inv_d, inv_q;

  bf16w_unbox #(.FLEN(FLEN)) u_unbox (
    .reg_val  (in_reg),
    .operand  (op),
    .boxed_ok (boxed_ok)
  );

  bf16w_classify u_class (
    .expo (op.expo),
    .frac (op.frac),
    .cls  (cls)
  );

  bf16w_expand #(.FLEN(FLEN)) u_expand (
    .operand  (op),
    .cls      (cls),
    .boxed_ok (boxed_ok),
    .result   (conv_res),
    .invalid  (conv_inv)
  );

  // next state: capture only on a strobe
  always_comb begin
    vld_d = in_vld;
    res_d = in_vld ? conv_res : res_q;
    inv_d = in_vld ? conv_inv : inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign out_vld     = vld_q;
  assign out_res     = res_q;
  assign out_invalid = inv_q;
endmodule

// File: rtl/bf16w_chk.sv
module bf16w_chk #(
  parameter int FLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic [FLEN-1:0] in_reg,
  input logic            out_vld,
  input logic [FLEN-1:0] out_res,
  input logic            out_invalid
);
  logic in_boxed;
  logic in_nan;
  logic in_snan;

  assign in_boxed = &in_reg[FLEN-1:16];
  assign in_nan   = (&in_reg[14:7]) && (|in_reg[6:0]);
  assign in_snan  = in_nan && !in_reg[6];

  initial a_flen_legal: assert (FLEN == 32 || FLEN == 64);

  // R1
  a_r1_exact_widen: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && in_boxed && !in_nan |=> out_res[31:0] == {$past(in_reg[15:0]), 16'h0000});

  generate
    if (FLEN > 32) begin : g_box_chk
      // R2
      a_r2_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> &out_res[FLEN-1:32]);
    end
  endgenerate

  // R3
  a_r3_unboxed_canon: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !in_boxed |=> out_res[31:0] == 32'h7FC0_0000 && !out_invalid);

  // R4
  a_r4_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && in_boxed && in_snan |=> out_invalid && out_res[31:0] == 32'h7FC0_0000);

  // R5
  a_r5_qnan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && in_boxed && in_nan && !in_snan |=> !out_invalid && out_res[31:0] == 32'h7FC0_0000);

  // R6
  a_r6_invalid_only_nan: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_res[31:0] == 32'h7FC0_0000);

  // R7
  a_r7_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r7_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res) && $stable(out_invalid));
endmodule

bind bf16_widen bf16w_chk #(.FLEN(FLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_vld      (in_vld),
  .in_reg      (in_reg),
  .out_vld     (out_vld),
  .out_res     (out_res),
  .out_invalid (out_invalid)
);

// File: tb/bf16_widen_tb.sv
module bf16_widen_tb;
  localparam int FLEN = 64;

  logic            clk;
  logic            rst_n;
  logic            in_vld;
  logic [FLEN-1:0] in_reg;
  logic            out_vld;
  logic [FLEN-1:0] out_res;
  logic            out_invalid;

  int n_chk;
  int n_bad;
  bit done;

  bf16_widen #(.FLEN(FLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_reg(in_reg),
    .out_vld(out_vld), .out_res(out_res), .out_invalid(out_invalid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [FLEN-1:0] BOX = {{(FLEN-16){1'b1}}, 16'h0000};

  function automatic logic [FLEN:0] model(input logic [FLEN-1:0] r);
    logic [15:0] op;
    logic [31:0] sp;
    logic        inv;
    op  = r[15:0];
    inv = 1'b0;
    if (r[FLEN-1:16] != {(FLEN-16){1'b1}}) sp = 32'h7FC0_0000;
    else if (op[14:7] == 8'hFF && op[6:0] != 7'd0) begin
      sp  = 32'h7FC0_0000;
      inv = (op[6] == 1'b0);
    end else sp = {op, 16'h0000};
    return {inv, {(FLEN-32){1'b1}}, sp};
  endfunction

  task automatic check(input string tag, input logic [FLEN-1:0] act,
                       input logic [FLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert(input string tag, input logic [FLEN-1:0] r);
    logic [FLEN:0] e;
    e = model(r);
    @(negedge clk);
    in_vld = 1'b1;
    in_reg = r;
    @(negedge clk);
    in_vld = 1'b0;
    in_reg = ~r;
    check({tag, " R7 vld"}, FLEN'(out_vld), FLEN'(1));
    check({tag, " res"}, out_res, e[FLEN-1:0]);
    check({tag, " R6 invalid"}, FLEN'(out_invalid), FLEN'(e[FLEN]));
    @(negedge clk);
    check({tag, " R7 idle vld"}, FLEN'(out_vld), FLEN'(0));
    check({tag, " R7 hold res"}, out_res, e[FLEN-1:0]);
    check({tag, " R7 hold inv"}, FLEN'(out_invalid), FLEN'(e[FLEN]));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] op;
    logic [FLEN-1:0] r;
    int unsigned seed;
    n_chk  = 0;
    n_bad  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_reg = '0;
    seed   = $urandom(32'h5EED_0BF1);
    repeat (3) @(negedge clk);
    check("R8 reset vld", FLEN'(out_vld), FLEN'(0));
    check("R8 reset res", out_res, '0);
    check("R8 reset inv", FLEN'(out_invalid), FLEN'(0));
    rst_n = 1'b1;

    convert("R1 +zero",       BOX | 64'h0000);
    convert("R1 -zero",       BOX | 64'h8000);
    convert("R1 min subnorm", BOX | 64'h0001);
    convert("R1 max normal",  BOX | 64'h7F7F);
    convert("R1 one",         BOX | 64'h3F80);
    convert("R1 +inf",        BOX | 64'h7F80);
    convert("R1 -inf",        BOX | 64'hFF80);
    convert("R4 snan",        BOX | 64'h7F81);
    convert("R4 neg snan",    BOX | 64'hFFBF);
    convert("R5 qnan",        BOX | 64'h7FC0);
    convert("R5 neg qnan pl", BOX | 64'hFFC1);
    convert("R3 upper zero",  64'h0000_0000_0000_3F80);
    convert("R3 bit16 clear", BOX & ~(64'd1 << 16) | 64'h7F81);
    convert("R3 bit63 clear", BOX & ~(64'd1 << 63) | 64'h3F80);
    convert("R2 box ones",    BOX | 64'h4049);

    for (int i = 0; i < 400; i++) begin
      op = 16'($urandom);
      case ($urandom % 4)
        0: op[14:7] = 8'hFF;
        1: op[14:7] = 8'h00;
        default: ;
      endcase
      r = BOX | FLEN'(op);
      if ($urandom % 4 == 0) r[FLEN-1:16] = {$urandom, $urandom};
      convert("R1/R3/R4/R5 random", r);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule